// File: doc/BRIEF.md
# Page Translation Cache with Global Entries

This block keeps a small, fully associative set of recent page translations in front of a page-table lookup port. A translation request carries a virtual page number and a page offset. If a valid entry holds that page, the block answers on the next cycle with the physical address, which is the cached frame number joined to the offset, along with the page's flag word. The table side is not used on a hit.

On a miss, the block sends a lookup request for the page to the table side and waits for the page-table entry. It then returns the translation built from that entry. If the entry is present, the block also installs it. If it is not present, the block reports a page fault and caches nothing.

Two plain control inputs keep the cache consistent with the tables. A single-page invalidate removes a translation after software has rewritten its table entry. A task-switch flush drops every entry except those marked global.

Both data paths use valid/ready handshakes. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low while a miss is in flight, and also while an earlier response is waiting with `rsp_ready` low. A response, once raised, holds its payload unchanged until it is accepted. The table-side request likewise holds `tw_req_valid` and `tw_req_vpn` until `tw_req_ready` is seen.

Top module: `tlb_top`

## Requirements
- R1: When a request is accepted and its page is held in a valid entry, `rsp_valid` rises on the next cycle. The response has `rsp_hit`=1, `rsp_fault`=0, `rsp_paddr` = {cached frame, request offset} and the cached flag word, and no table request is issued.
- R2: When a request is accepted and its page is not cached, the block raises `tw_req_valid` with `tw_req_vpn` set to the page. The table entry arrives on `tw_rsp_pte` as {frame, flags[8:0]}, with the frame in the top bits. If flag bit 0 (present) is set, the block installs the entry and answers with `rsp_hit`=0, `rsp_fault`=0, `rsp_paddr` = {frame, offset} and the flag word.
- R3: A table entry with flag bit 0 clear produces `rsp_fault`=1 with `rsp_paddr`=0 and is not installed. A later request for the same page therefore goes to the table side again.
- R4: A fill goes to the lowest-numbered empty entry. When every entry is valid, it replaces the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each such replacement.
- R5: A one-cycle pulse on `flush_nonglobal` invalidates every entry whose flag bit 8 (global) is clear and keeps every entry with that bit set. A non-global fill in the same cycle as the flush is not installed.
- R6: A one-cycle pulse on `inv_valid` invalidates the entry for page `inv_vpn`, so the next request for that page misses. Other entries are unaffected.
- R7: If an invalidate names the page being filled in the same cycle, the invalidate wins. The response is still delivered, but the entry is not installed, so the next request for that page misses.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response payload holds steady and `req_ready` stays low. `req_ready` is also low during a miss.
- R9: After reset, no entry is valid, `req_ready` is high, and `rsp_valid` and `tw_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can take a request |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | OFF_W | Page offset |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, 0 on fault |
| rsp_flags | output | 9 | Flag word of the page |
| rsp_fault | output | 1 | Page not present |
| rsp_hit | output | 1 | Answer came from the cache |
| tw_req_valid | output | 1 | Table lookup request valid |
| tw_req_ready | input | 1 | Table side takes the request |
| tw_req_vpn | output | VPN_W | Page to look up |
| tw_rsp_valid | input | 1 | Table entry valid |
| tw_rsp_ready | output | 1 | Block takes the table entry |
| tw_rsp_pte | input | PFN_W+9 | Table entry {frame, flags} |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | VPN_W | Page to invalidate |
| flush_nonglobal | input | 1 | Drop all non-global entries |

## Verification
The bench builds the block with its defaults: 8 entries, a 4-bit page number, a 3-bit frame and a 4-bit offset. Because the 16 possible pages are twice the entry count, a sweep over every page fills the cache from empty, wraps the round-robin pointer and evicts live entries. Every page can be checked against an arithmetic page table and a slot-level model. The small space also lets the invalidate, flush and collision cases be aimed at chosen cached and uncached pages, with table latencies of zero to two cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int FLAG_W      = 9;
  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_GLOBAL  = 8;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_REQ  = 2'd1,
    MS_WAIT = 2'd2
  } miss_state_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 4,
  parameter int PFN_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic               look_hit,
  output logic [PFN_W-1:0]   look_pfn,
  output logic [FLAG_W-1:0]  look_flags,
  input  logic               inv_valid,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic               flush,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic [FLAG_W-1:0]  fill_flags,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [PFN_W-1:0]   pfn_q   [ENTRIES];
  logic [FLAG_W-1:0]  flags_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] kill;
  logic [ENTRIES-1:0] glob_vec;

  // Compare every tag with the lookup page and OR together the hit data.
  always_comb begin
    look_pfn   = '0;
    look_flags = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i]    = valid_q[i] && (tag_q[i] == look_vpn);
      glob_vec[i] = flags_q[i][FLAG_GLOBAL];
      kill[i]     = valid_q[i] &&
                    ((inv_valid && (tag_q[i] == inv_vpn)) ||
                     (flush && !flags_q[i][FLAG_GLOBAL]));
      if (match[i]) begin
        look_pfn   = look_pfn | pfn_q[i];
        look_flags = look_flags | flags_q[i];
      end
    end
  end
  assign look_hit  = |match;
  assign valid_vec = valid_q;

  // A kill is decided from the old contents. The fill is applied last, so a
  // fresh entry is not killed by an invalidate aimed at the page it replaces.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (kill[i]) valid_q[i] <= 1'b0;
        if (fill_en && (fill_idx == IDX_W'(i))) valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_en && (fill_idx == IDX_W'(i))) begin
        tag_q[i]   <= fill_vpn;
        pfn_q[i]   <= fill_pfn;
        flags_q[i] <= fill_flags;
      end
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R4

  AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((valid_q & ~glob_vec) == '0)); // R5

  for (genvar g = 0; g < ENTRIES; g++) begin : g_inv_chk
    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |=> !(valid_q[g] && (tag_q[g] == $past(inv_vpn)))); // R6
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               all_full
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;

  // Scan from the top down so the lowest empty slot is the one that remains.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign all_full   = &valid_vec;
  assign victim_idx = all_full ? rr_q : free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fill_en && all_full) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_VICTIM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !all_full |-> !valid_vec[victim_idx]); // R4
endmodule

// File: rtl/tlb_miss_fsm.sv
module tlb_miss_fsm
  import tlb_pkg::*;
#(
  parameter int VPN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  output miss_state_e      state,
  output logic [VPN_W-1:0] miss_vpn,
  output logic             tw_req_valid,
  input  logic             tw_req_ready,
  output logic [VPN_W-1:0] tw_req_vpn,
  input  logic             tw_rsp_valid,
  output logic             tw_rsp_ready,
  output logic             done
);
  miss_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= MS_IDLE;
      miss_vpn <= '0;
    end else begin
      case (state_q)
        MS_IDLE: if (start) begin
          state_q  <= MS_REQ;
          miss_vpn <= start_vpn;
        end
        MS_REQ:  if (tw_req_ready) state_q <= MS_WAIT;
        MS_WAIT: if (tw_rsp_valid) state_q <= MS_IDLE;
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign state        = state_q;
  assign tw_req_valid = (state_q == MS_REQ);
  assign tw_req_vpn   = miss_vpn;
  assign tw_rsp_ready = (state_q == MS_WAIT);
  assign done         = tw_rsp_ready && tw_rsp_valid;

  AST_TW_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_req_valid && !tw_req_ready) |=> (tw_req_valid && $stable(tw_req_vpn))); // R2
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 4,
  parameter int PFN_W   = 3,
  parameter int OFF_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PTE_W  = PFN_W + FLAG_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [OFF_W-1:0]  req_off,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic              rsp_fault,
  output logic              rsp_hit,
  output logic              tw_req_valid,
  input  logic              tw_req_ready,
  output logic [VPN_W-1:0]  tw_req_vpn,
  input  logic              tw_rsp_valid,
  output logic              tw_rsp_ready,
  input  logic [PTE_W-1:0]  tw_rsp_pte,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              flush_nonglobal
);
  miss_state_e        state;
  logic [VPN_W-1:0]   miss_vpn;
  logic               done;
  logic               look_hit;
  logic [PFN_W-1:0]   look_pfn;
  logic [FLAG_W-1:0]  look_flags;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim_idx;
  logic               all_full;
  logic               accept;
  logic               fill_en;
  logic [OFF_W-1:0]   off_q;
  logic [PFN_W-1:0]   pte_pfn;
  logic [FLAG_W-1:0]  pte_flags;
  logic               pte_present;

  assign pte_pfn     = tw_rsp_pte[PTE_W-1:FLAG_W];
  assign pte_flags   = tw_rsp_pte[FLAG_W-1:0];
  assign pte_present = pte_flags[FLAG_PRESENT];

  assign req_ready = (state == MS_IDLE) && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  // A fill is blocked by a same-cycle invalidate of the page being filled,
  // or by a flush when the new entry is not global.
  assign fill_en = done && pte_present &&
                   !(inv_valid && (inv_vpn == miss_vpn)) &&
                   !(flush_nonglobal && !pte_flags[FLAG_GLOBAL]);

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_vpn   (req_vpn),
    .look_hit   (look_hit),
    .look_pfn   (look_pfn),
    .look_flags (look_flags),
    .inv_valid  (inv_valid),
    .inv_vpn    (inv_vpn),
    .flush      (flush_nonglobal),
    .fill_en    (fill_en),
    .fill_idx   (victim_idx),
    .fill_vpn   (miss_vpn),
    .fill_pfn   (pte_pfn),
    .fill_flags (pte_flags),
    .valid_vec  (valid_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .fill_en    (fill_en),
    .victim_idx (victim_idx),
    .all_full   (all_full)
  );

  tlb_miss_fsm #(.VPN_W(VPN_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept && !look_hit),
    .start_vpn    (req_vpn),
    .state        (state),
    .miss_vpn     (miss_vpn),
    .tw_req_valid (tw_req_valid),
    .tw_req_ready (tw_req_ready),
    .tw_req_vpn   (tw_req_vpn),
    .tw_rsp_valid (tw_rsp_valid),
    .tw_rsp_ready (tw_rsp_ready),
    .done         (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (accept) begin
      off_q <= req_off;
    end
  end

  // The response register loads on a hit or on a table answer. A new load
  // happens only when the register is empty or being drained this cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_flags <= '0;
      rsp_fault <= 1'b0;
      rsp_hit   <= 1'b0;
    end else if (accept && look_hit) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= {look_pfn, req_off};
      rsp_flags <= look_flags;
      rsp_fault <= 1'b0;
      rsp_hit   <= 1'b1;
    end else if (done) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= pte_present ? {pte_pfn, off_q} : '0;
      rsp_flags <= pte_flags;
      rsp_fault <= !pte_present;
      rsp_hit   <= 1'b0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_flags))); // R8

  AST_NO_TW_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && look_hit) |=> !tw_req_valid); // R1

  AST_FAULT_NOT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pte_present) |-> !fill_en); // R3
endmodule

// File: tb/tlb_top_tb.sv
`timescale 1ns/1ps
module tlb_top_tb;
  localparam int ENTRIES = 8;
  localparam int VPN_W = 4;
  localparam int PFN_W = 3;
  localparam int OFF_W = 4;
  localparam int PA_W  = PFN_W + OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic req_ready, rsp_valid, rsp_fault, rsp_hit;
  logic [PA_W-1:0] rsp_paddr;
  logic [8:0] rsp_flags;
  logic tw_req_valid, tw_rsp_ready;
  logic tw_req_ready = 1'b0, tw_rsp_valid = 1'b0;
  logic [VPN_W-1:0] tw_req_vpn;
  logic [PFN_W+8:0] tw_rsp_pte = '0;
  logic inv_valid = 1'b0, flush_nonglobal = 1'b0;
  logic [VPN_W-1:0] inv_vpn = '0;

  int n_cmp = 0;
  int n_bad = 0;

  // Model of the slots, built from the fill rules.
  int m_vpn [ENTRIES];
  bit m_v   [ENTRIES];
  int m_rr = 0;

  always #4 clk = ~clk;

  tlb_top #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_flags(rsp_flags), .rsp_fault(rsp_fault), .rsp_hit(rsp_hit),
    .tw_req_valid(tw_req_valid), .tw_req_ready(tw_req_ready), .tw_req_vpn(tw_req_vpn),
    .tw_rsp_valid(tw_rsp_valid), .tw_rsp_ready(tw_rsp_ready), .tw_rsp_pte(tw_rsp_pte),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush_nonglobal(flush_nonglobal)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Arithmetic page table: flag bit 0 present, bit 8 global.
  function automatic int pt_pfn(input int v);
    return (v * 5 + 3) % 8;
  endfunction
  function automatic int pt_flags(input int v);
    int f;
    f = 0;
    f |= (v != 0) ? 1 : 0;
    f |= (v & 1) << 1;
    f |= ((v >> 1) & 1) << 2;
    f |= ((v >> 3) & 1) << 4;
    f |= 1 << 5;
    f |= ((v & 1) & ((v >> 1) & 1)) << 6;
    f |= ((v % 3) == 0 ? 1 : 0) << 8;
    return f;
  endfunction

  function automatic bit m_hit(input int v);
    for (int i = 0; i < ENTRIES; i++) if (m_v[i] && m_vpn[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_fill(input int v);
    int slot;
    slot = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % ENTRIES;
    end
    m_v[slot] = 1'b1;
    m_vpn[slot] = v;
  endtask

  task automatic xlate(input int v, input int off, input int lat, input bit inv_same,
                       output bit walked, output bit hit, output bit fault,
                       output int paddr, output int flags);
    walked = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = VPN_W'(v); req_off = OFF_W'(off);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 50; k++) begin
      if (rsp_valid) break;
      if (tw_req_valid) begin
        walked = 1'b1;
        chk("R2", "table request page", int'(tw_req_vpn), v);
        repeat (lat) @(negedge clk);
        tw_req_ready = 1'b1;
        @(negedge clk);
        tw_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        tw_rsp_valid = 1'b1;
        tw_rsp_pte = {PFN_W'(pt_pfn(v)), 9'(pt_flags(v))};
        if (inv_same) begin
          inv_valid = 1'b1; inv_vpn = VPN_W'(v);
        end
        @(negedge clk);
        tw_rsp_valid = 1'b0; inv_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    hit = rsp_hit; fault = rsp_fault; paddr = int'(rsp_paddr); flags = int'(rsp_flags);
    if (!rsp_valid) chk("R2", "response arrived", 0, 1);
    @(negedge clk);
  endtask

  task automatic run(input int v, input int off, input int lat, input bit inv_same, input string tag);
    bit exp_hit, present, walked, hit, fault;
    int paddr, flags;
    exp_hit = m_hit(v);
    present = (pt_flags(v) & 1) != 0;
    xlate(v, off, lat, inv_same, walked, hit, fault, paddr, flags);
    chk(tag, $sformatf("hit page %0d", v), int'(hit), int'(exp_hit));
    chk(tag, $sformatf("walk page %0d", v), int'(walked), int'(!exp_hit));
    chk(present ? tag : "R3", $sformatf("fault page %0d", v), int'(fault), int'(!present));
    if (present) begin
      chk(tag, $sformatf("paddr page %0d", v), paddr, pt_pfn(v) * 16 + off);
      chk(tag, $sformatf("flags page %0d", v), flags, pt_flags(v));
      if (!exp_hit && !inv_same) m_fill(v);
    end else begin
      chk("R3", "fault paddr", paddr, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pick;
    for (int i = 0; i < ENTRIES; i++) begin m_v[i] = 1'b0; m_vpn[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "req_ready after reset", int'(req_ready), 1);
    chk("R9", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R9", "tw_req_valid after reset", int'(tw_req_valid), 0);

    // Fill from empty, then overflow into round-robin replacement.
    for (int v = 0; v < 16; v++) run(v, v ^ 5, v % 3, 1'b0, m_hit(v) ? "R1" : "R2");
    // Reverse sweep: hits and evictions follow the slot model.
    for (int v = 15; v >= 0; v--) run(v, (~v) & 15, (v + 1) % 3, 1'b0, "R4");
    // Faulting page twice: each one walks.
    run(0, 3, 0, 1'b0, "R3");

    // Single-page invalidate of a cached page.
    pick = -1;
    for (int i = 0; i < ENTRIES; i++) if (m_v[i] && pick < 0) pick = m_vpn[i];
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = VPN_W'(pick);
    @(negedge clk);
    inv_valid = 1'b0;
    for (int i = 0; i < ENTRIES; i++) if (m_v[i] && m_vpn[i] == pick) m_v[i] = 1'b0;
    run(pick, 9, 1, 1'b0, "R6");
    for (int i = 0; i < ENTRIES; i++) if (m_v[i]) run(m_vpn[i], i, 0, 1'b0, "R6");

    // Task-switch flush keeps only global entries.
    @(negedge clk);
    flush_nonglobal = 1'b1;
    @(negedge clk);
    flush_nonglobal = 1'b0;
    for (int i = 0; i < ENTRIES; i++) if (m_v[i] && ((pt_flags(m_vpn[i]) >> 8) & 1) == 0) m_v[i] = 1'b0;
    for (int v = 1; v < 16; v++) run(v, v, 2, 1'b0, "R5");

    // Invalidate colliding with the fill of the same page.
    pick = -1;
    for (int v = 1; v < 16; v++) if (!m_hit(v) && pick < 0) pick = v;
    run(pick, 6, 1, 1'b1, "R7");
    run(pick, 7, 0, 1'b0, "R7");

    // Back-pressure on a hit response.
    pick = -1;
    for (int i = 0; i < ENTRIES; i++) if (m_v[i] && pick < 0) pick = m_vpn[i];
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vpn = VPN_W'(pick); req_off = 4'd11;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "req_ready while stalled", int'(req_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8", "rsp_valid held", int'(rsp_valid), 1);
      chk("R8", "paddr held", int'(rsp_paddr), pt_pfn(pick) * 16 + 11);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R8", "rsp_valid after accept", int'(rsp_valid), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule